// File: doc/BRIEF.md
# Programmable Event Counter with Selector

This block is one programmable performance counter together with its 64-bit selector word. Each clock cycle it sees a set of event lanes. Each lane carries a valid bit, an 8-bit event code and an 8-bit qualifier mask. A single privilege input tells whether the core is in user or kernel mode. The selector decides which code and qualifier pair is counted and in which privilege modes. It also sets how the matching lanes of one cycle become an increment: added up, or reduced by threshold, invert and edge modifiers to at most one count per cycle.

Software reaches the selector and the 48-bit count through a simple register port: one write strobe, one select bit and a combinational read path. A sampling period of N events is set by writing the count with minus N, taken to 48 bits. The counter then crosses zero after exactly N more counted events. That crossing produces a one-cycle overflow pulse and, if the selector asks for it, an interrupt request that stays high until it is acknowledged. A global enable input from outside gates all counting.

Top module: `perf_event_counter`

## Requirements
- R1: A lane is a match when its valid bit is high, its code equals selector bits 7:0 and its qualifier equals selector bits 15:8. With a zero threshold, the count rises by the number of matching lanes in that cycle.
- R2: Selector bit 16 allows counting while `priv_kernel` is 0 (user). Selector bit 17 allows counting while `priv_kernel` is 1 (kernel). When the bit for the current mode is clear, the count does not change.
- R3: Counting needs selector bit 22 and the `glb_en` input both high. If either is low, the count holds its value.
- R4: `reg_sel` = 0 addresses the selector and `reg_sel` = 1 addresses the count. A write to the selector stores all 64 bits, and reading it back returns them unchanged. A write to the count keeps only the low 48 bits, and reading the count returns zeros above bit 47.
- R5: With a zero threshold, the increment for one cycle saturates at 15, which is the limit of the 4-bit per-cycle increment.
- R6: With a nonzero threshold in selector bits 31:24, a cycle adds exactly one when the number of matching lanes is at or above the threshold. Otherwise it adds zero.
- R7: Selector bit 23 (invert) changes the threshold test to "fewer matching lanes than the threshold". It has no effect when the threshold is zero.
- R8: Selector bit 18 (edge), with a nonzero threshold, adds one only in a cycle where the threshold condition is true and was false in the previous counting cycle. The history is cleared while counting is inactive. Edge has no effect when the threshold is zero.
- R9: When a count whose bit 47 is set wraps to a value whose bit 47 is clear, `ovf_pulse` is high for exactly one cycle. That is the same cycle in which the wrapped count first becomes readable. A preload of minus N therefore reaches 0 and pulses on the Nth counted event.
- R10: If selector bit 20 is set, an overflow raises `irq`, which stays high until a cycle with `irq_ack` high. A new overflow in the same cycle as an acknowledge wins. With bit 20 clear, an overflow still pulses but `irq` stays low.
- R11: A count write in the same cycle as a counted event stores the written value, and that cycle's increment is discarded.
- R12: After reset the selector and the count read as zero, and `ovf_pulse` and `irq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| glb_en | input | 1 | Global enable for counting |
| priv_kernel | input | 1 | Current privilege: 1 kernel, 0 user |
| lane_valid | input | NUM_LANES | Event present on each lane |
| lane_code | input | 8*NUM_LANES | Event code per lane; lane i uses bits 8i+7:8i |
| lane_umask | input | 8*NUM_LANES | Qualifier mask per lane, same packing as the codes |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the selector word, 1 selects the count |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data for the register chosen by `reg_sel` |
| irq_ack | input | 1 | Clears a pending interrupt request |
| ovf_pulse | output | 1 | One-cycle overflow indication |
| irq | output | 1 | Held interrupt request |

## Verification
A wrong match, privilege or enable decision shows up in the count readback on the cycle right after the edge in which the event was sampled. A mistake in threshold, invert or edge handling shows up as the count moving by the wrong amount on that same cycle, so the bench compares the count after every event cycle. Broken wrap detection shows as a missing or extra `ovf_pulse` in the cycle where the count reaches zero. A wrong interrupt state shows as `irq` failing to rise there, or failing to stay high until the acknowledge cycle and drop one cycle later.

// File: rtl/perf_ctr_pkg.sv
package perf_ctr_pkg;

  localparam int SEL_W = 64;

  // selector bit positions (software-visible layout)
  localparam int B_USR  = 16;
  localparam int B_OS   = 17;
  localparam int B_EDGE = 18;
  localparam int B_INT  = 20;
  localparam int B_EN   = 22;
  localparam int B_INV  = 23;

  typedef struct packed {
    logic [7:0] thresh;
    logic       invert;
    logic       cnt_en;
    logic       int_en;
    logic       edge_m;
    logic       os_ok;
    logic       usr_ok;
    logic [7:0] qual;
    logic [7:0] code;
  } sel_fields_t;

  function automatic sel_fields_t decode_sel(input logic [SEL_W-1:0] w);
    sel_fields_t f;
    f.code   = w[7:0];
    f.qual   = w[15:8];
    f.usr_ok = w[B_USR];
    f.os_ok  = w[B_OS];
    f.edge_m = w[B_EDGE];
    f.int_en = w[B_INT];
    f.cnt_en = w[B_EN];
    f.invert = w[B_INV];
    f.thresh = w[31:24];
    return f;
  endfunction

  // privilege qualification for the current cycle
  function automatic logic priv_allows(input logic kern, input sel_fields_t f);
    return kern ? f.os_ok : f.usr_ok;
  endfunction

  // threshold test, optionally inverted
  function automatic logic thresh_cond(input logic [15:0] hits,
                                       input logic [7:0]  thr,
                                       input logic        inv);
    logic ge;
    ge = (hits >= {8'd0, thr});
    return inv ? ~ge : ge;
  endfunction

endpackage

// File: rtl/pc_lane_match.sv
module pc_lane_match #(
  parameter int NUM_LANES = 4
) (
  input  logic [NUM_LANES-1:0]   lane_valid,
  input  logic [8*NUM_LANES-1:0] lane_code,
  input  logic [8*NUM_LANES-1:0] lane_umask,
  input  logic [7:0]             want_code,
  input  logic [7:0]             want_qual,
  output logic [NUM_LANES-1:0]   hit_vec
);

  for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
    logic code_eq;
    logic qual_eq;
    assign code_eq    = (lane_code[8*i +: 8] == want_code);
    assign qual_eq    = (lane_umask[8*i +: 8] == want_qual);
    assign hit_vec[i] = lane_valid[i] & code_eq & qual_eq;
  end

endmodule

// File: rtl/pc_qualifier.sv
module pc_qualifier #(
  parameter int NUM_LANES = 4,
  parameter int INC_W     = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LANES-1:0] hit_vec,
  input  logic                 active,
  input  logic [7:0]           thresh,
  input  logic                 invert,
  input  logic                 edge_m,
  output logic [INC_W-1:0]     inc_amt,
  output logic [15:0]          hit_cnt,
  output logic                 thr_cond
);
  import perf_ctr_pkg::*;

  localparam logic [15:0] INC_MAX = 16'((1 << INC_W) - 1);

  function automatic logic [15:0] count_hits(input logic [NUM_LANES-1:0] v);
    logic [15:0] s;
    s = '0;
    for (int i = 0; i < NUM_LANES; i++) s = s + 16'(v[i]);
    return s;
  endfunction

  function automatic logic [INC_W-1:0] sat_inc(input logic [15:0] s);
    return (s > INC_MAX) ? INC_W'(INC_MAX) : INC_W'(s);
  endfunction

  logic prev_cond_q;
  logic thr_on;
  logic thr_hit;

  assign hit_cnt  = count_hits(hit_vec);
  assign thr_on   = (thresh != 8'd0);
  assign thr_cond = thresh_cond(hit_cnt, thresh, invert);
  assign thr_hit  = edge_m ? (thr_cond & ~prev_cond_q) : thr_cond;

  always_comb begin
    if (!active)     inc_amt = '0;
    else if (thr_on) inc_amt = INC_W'(thr_hit);
    else             inc_amt = sat_inc(hit_cnt);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      prev_cond_q <= 1'b0;
    else if (active) prev_cond_q <= thr_cond;
    else             prev_cond_q <= 1'b0;
  end

endmodule

// File: rtl/pc_counter.sv
module pc_counter #(
  parameter int CNT_W = 48,
  parameter int INC_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_en,
  input  logic [CNT_W-1:0] ld_val,
  input  logic [INC_W-1:0] inc_amt,
  input  logic             int_en,
  input  logic             irq_ack,
  output logic [CNT_W-1:0] cnt_q,
  output logic             wrap_evt,
  output logic             ovf_pulse,
  output logic             irq
);

  function automatic logic crossed_zero(input logic [CNT_W-1:0] old_v,
                                        input logic [CNT_W-1:0] new_v);
    return old_v[CNT_W-1] & ~new_v[CNT_W-1];
  endfunction

  logic [CNT_W-1:0] cnt_next;

  assign cnt_next = cnt_q + CNT_W'(inc_amt);
  assign wrap_evt = ~ld_en & (inc_amt != '0) & crossed_zero(cnt_q, cnt_next);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      ovf_pulse <= 1'b0;
      irq       <= 1'b0;
    end else begin
      cnt_q     <= ld_en ? ld_val : cnt_next;
      ovf_pulse <= wrap_evt;
      if (wrap_evt && int_en) irq <= 1'b1;
      else if (irq_ack)       irq <= 1'b0;
    end
  end

endmodule

// File: rtl/perf_event_counter.sv
module perf_event_counter #(
  parameter int NUM_LANES = 4,
  parameter int CNT_W     = 48,
  parameter int INC_W     = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   glb_en,
  input  logic                   priv_kernel,
  input  logic [NUM_LANES-1:0]   lane_valid,
  input  logic [8*NUM_LANES-1:0] lane_code,
  input  logic [8*NUM_LANES-1:0] lane_umask,
  input  logic                   reg_wr,
  input  logic                   reg_sel,
  input  logic [63:0]            reg_wdata,
  output logic [63:0]            reg_rdata,
  input  logic                   irq_ack,
  output logic                   ovf_pulse,
  output logic                   irq
);
  import perf_ctr_pkg::*;

  localparam int PAD_W = SEL_W - CNT_W;

  logic [SEL_W-1:0]     ctl_q;
  sel_fields_t          fld;
  logic                 active;
  logic [NUM_LANES-1:0] hit_vec;
  logic [INC_W-1:0]     inc_amt;
  logic [15:0]          hit_cnt;
  logic                 thr_cond;
  logic [CNT_W-1:0]     cnt_q;
  logic                 wrap_evt;
  logic                 ld_cnt;

  assign fld    = decode_sel(ctl_q);
  assign active = glb_en & fld.cnt_en & priv_allows(priv_kernel, fld);
  assign ld_cnt = reg_wr & reg_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  ctl_q <= '0;
    else if (reg_wr && !reg_sel) ctl_q <= reg_wdata;
  end

  pc_lane_match #(.NUM_LANES(NUM_LANES)) u_match (
    .lane_valid (lane_valid),
    .lane_code  (lane_code),
    .lane_umask (lane_umask),
    .want_code  (fld.code),
    .want_qual  (fld.qual),
    .hit_vec    (hit_vec)
  );

  pc_qualifier #(.NUM_LANES(NUM_LANES), .INC_W(INC_W)) u_qual (
    .clk      (clk),
    .rst_n    (rst_n),
    .hit_vec  (hit_vec),
    .active   (active),
    .thresh   (fld.thresh),
    .invert   (fld.invert),
    .edge_m   (fld.edge_m),
    .inc_amt  (inc_amt),
    .hit_cnt  (hit_cnt),
    .thr_cond (thr_cond)
  );

  pc_counter #(.CNT_W(CNT_W), .INC_W(INC_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .ld_en     (ld_cnt),
    .ld_val    (reg_wdata[CNT_W-1:0]),
    .inc_amt   (inc_amt),
    .int_en    (fld.int_en),
    .irq_ack   (irq_ack),
    .cnt_q     (cnt_q),
    .wrap_evt  (wrap_evt),
    .ovf_pulse (ovf_pulse),
    .irq       (irq)
  );

  assign reg_rdata = reg_sel ? {{PAD_W{1'b0}}, cnt_q} : ctl_q;

endmodule

// File: rtl/pc_checker.sv
module pc_checker #(
  parameter int CNT_W = 48,
  parameter int INC_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             glb_en,
  input logic             priv_kernel,
  input logic             reg_wr,
  input logic             irq_ack,
  input logic             ovf_pulse,
  input logic             irq,
  input logic [63:0]      ctl_q,
  input logic [CNT_W-1:0] cnt_q,
  input logic [INC_W-1:0] inc_amt,
  input logic             wrap_evt
);

  AST_HOLD_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_q[22] && !reg_wr) |=> $stable(cnt_q)); // R3

  AST_GLOBAL_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    !glb_en |-> (inc_amt == '0)); // R3

  AST_PRIV_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    ((priv_kernel && !ctl_q[17]) || (!priv_kernel && !ctl_q[16])) |-> (inc_amt == '0)); // R2

  AST_THRESH_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q[31:24] != 8'd0) |-> (inc_amt <= INC_W'(1))); // R6

  AST_OVF_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_pulse |=> !ovf_pulse); // R9

  AST_OVF_FOLLOWS_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> ovf_pulse); // R9

  AST_IRQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_ack) |=> irq); // R10

  AST_IRQ_NEEDS_OVF: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ovf_pulse); // R10

endmodule

bind perf_event_counter pc_checker #(.CNT_W(CNT_W), .INC_W(INC_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .glb_en      (glb_en),
  .priv_kernel (priv_kernel),
  .reg_wr      (reg_wr),
  .irq_ack     (irq_ack),
  .ovf_pulse   (ovf_pulse),
  .irq         (irq),
  .ctl_q       (ctl_q),
  .cnt_q       (cnt_q),
  .inc_amt     (inc_amt),
  .wrap_evt    (wrap_evt)
);

// File: tb/perf_event_counter_test.sv
module perf_event_counter_test;

  localparam int L = 20;
  localparam logic [47:0] M48 = '1;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          glb_en, priv_kernel, reg_wr, reg_sel, irq_ack;
  logic [L-1:0]  lane_valid;
  logic [8*L-1:0] lane_code, lane_umask;
  logic [63:0]   reg_wdata, reg_rdata;
  logic          ovf_pulse, irq;

  int checks = 0;
  int failures = 0;
  logic [47:0] exp_cnt;

  always #5 clk = ~clk;

  perf_event_counter #(.NUM_LANES(L)) uut (
    .clk(clk), .rst_n(rst_n), .glb_en(glb_en), .priv_kernel(priv_kernel),
    .lane_valid(lane_valid), .lane_code(lane_code), .lane_umask(lane_umask),
    .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_ack(irq_ack), .ovf_pulse(ovf_pulse), .irq(irq)
  );

  function automatic logic [63:0] mk(input logic [7:0] code, input logic [7:0] um,
                                     input logic usr, input logic os, input logic edg,
                                     input logic ien, input logic en, input logic inv,
                                     input logic [7:0] thr);
    logic [63:0] w;
    w = '0;
    w[7:0] = code; w[15:8] = um; w[16] = usr; w[17] = os; w[18] = edg;
    w[20] = ien; w[22] = en; w[23] = inv; w[31:24] = thr;
    return w;
  endfunction

  function automatic logic [L-1:0] lanes(input int n);
    logic [L-1:0] v;
    v = '0;
    for (int i = 0; i < n; i++) v[i] = 1'b1;
    return v;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic sel, output logic [63:0] d);
    reg_sel = sel;
    #1;
    d = reg_rdata;
    reg_sel = 1'b1;
  endtask

  task automatic wr(input logic sel, input logic [63:0] d);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_sel = 1'b1;
  endtask

  task automatic ev(input logic [L-1:0] v, input logic [L-1:0] bad,
                    input logic [7:0] code, input logic [7:0] um,
                    input logic kern, input logic g);
    lane_valid = v;
    for (int i = 0; i < L; i++) begin
      lane_code[8*i +: 8]  = bad[i] ? ~code : code;
      lane_umask[8*i +: 8] = um;
    end
    priv_kernel = kern; glb_en = g;
    @(negedge clk);
    lane_valid = '0; glb_en = 1'b0;
  endtask

  task automatic chk_cnt(input string req);
    logic [63:0] d;
    rd(1'b1, d);
    chk(req, d, {16'd0, exp_cnt});
  endtask

  task automatic setup(input logic [63:0] ctl, input logic [47:0] start);
    wr(1'b0, ctl);
    wr(1'b1, {16'd0, start});
    exp_cnt = start;
  endtask

  task automatic t_reset();
    logic [63:0] d;
    rd(1'b0, d); chk("R12 selector", d, 64'd0);
    rd(1'b1, d); chk("R12 count", d, 64'd0);
    chk("R12 ovf", {63'd0, ovf_pulse}, 64'd0);
    chk("R12 irq", {63'd0, irq}, 64'd0);
  endtask

  task automatic t_match();
    setup(mk(8'h3C, 8'h01, 1, 1, 0, 0, 1, 0, 8'd0), 48'd0);
    ev(lanes(3), '0, 8'h3C, 8'h01, 0, 1); exp_cnt += 3; chk_cnt("R1 three lanes");
    ev(lanes(4), 20'b0101, 8'h3C, 8'h01, 0, 1); exp_cnt += 2; chk_cnt("R1 code mismatch lanes");
    ev(lanes(4), '0, 8'h3C, 8'h02, 0, 1); chk_cnt("R1 qualifier mismatch");
    ev('0, '0, 8'h3C, 8'h01, 0, 1); chk_cnt("R1 no valid lanes");
  endtask

  task automatic t_priv();
    setup(mk(8'h11, 8'h22, 1, 0, 0, 0, 1, 0, 8'd0), 48'd100);
    ev(lanes(5), '0, 8'h11, 8'h22, 1, 1); chk_cnt("R2 kernel blocked");
    ev(lanes(5), '0, 8'h11, 8'h22, 0, 1); exp_cnt += 5; chk_cnt("R2 user counted");
    wr(1'b0, mk(8'h11, 8'h22, 0, 1, 0, 0, 1, 0, 8'd0));
    ev(lanes(2), '0, 8'h11, 8'h22, 0, 1); chk_cnt("R2 user blocked");
    ev(lanes(2), '0, 8'h11, 8'h22, 1, 1); exp_cnt += 2; chk_cnt("R2 kernel counted");
  endtask

  task automatic t_enable();
    setup(mk(8'h05, 8'h00, 1, 1, 0, 0, 0, 0, 8'd0), 48'd7);
    ev(lanes(3), '0, 8'h05, 8'h00, 0, 1); chk_cnt("R3 enable bit clear");
    wr(1'b0, mk(8'h05, 8'h00, 1, 1, 0, 0, 1, 0, 8'd0));
    ev(lanes(3), '0, 8'h05, 8'h00, 0, 0); chk_cnt("R3 global low");
    ev(lanes(3), '0, 8'h05, 8'h00, 0, 1); exp_cnt += 3; chk_cnt("R3 both high");
  endtask

  task automatic t_sat();
    setup(mk(8'h40, 8'h04, 1, 1, 0, 0, 1, 0, 8'd0), 48'd0);
    ev(lanes(20), '0, 8'h40, 8'h04, 0, 1); exp_cnt += 15; chk_cnt("R5 twenty lanes");
    ev(lanes(15), '0, 8'h40, 8'h04, 0, 1); exp_cnt += 15; chk_cnt("R5 fifteen lanes");
    ev(lanes(7), '0, 8'h40, 8'h04, 0, 1); exp_cnt += 7; chk_cnt("R5 seven lanes");
  endtask

  task automatic t_thresh();
    setup(mk(8'h40, 8'h04, 1, 1, 0, 0, 1, 0, 8'd2), 48'd0);
    ev(lanes(3), '0, 8'h40, 8'h04, 0, 1); exp_cnt += 1; chk_cnt("R6 above");
    ev(lanes(1), '0, 8'h40, 8'h04, 0, 1); chk_cnt("R6 below");
    ev(lanes(2), '0, 8'h40, 8'h04, 0, 1); exp_cnt += 1; chk_cnt("R6 equal");
    ev(lanes(20), '0, 8'h40, 8'h04, 0, 1); exp_cnt += 1; chk_cnt("R6 many");
  endtask

  task automatic t_invert();
    setup(mk(8'h40, 8'h04, 1, 1, 0, 0, 1, 1, 8'd2), 48'd0);
    ev(lanes(1), '0, 8'h40, 8'h04, 0, 1); exp_cnt += 1; chk_cnt("R7 one below");
    ev('0, '0, 8'h40, 8'h04, 0, 1); exp_cnt += 1; chk_cnt("R7 zero below");
    ev(lanes(3), '0, 8'h40, 8'h04, 0, 1); chk_cnt("R7 above");
    wr(1'b0, mk(8'h40, 8'h04, 1, 1, 0, 0, 1, 1, 8'd0));
    ev(lanes(3), '0, 8'h40, 8'h04, 0, 1); exp_cnt += 3; chk_cnt("R7 ignored at zero threshold");
  endtask

  task automatic t_edge();
    setup(mk(8'h40, 8'h04, 1, 1, 1, 0, 1, 0, 8'd2), 48'd0);
    ev(lanes(3), '0, 8'h40, 8'h04, 0, 1); exp_cnt += 1; chk_cnt("R8 first rise");
    ev(lanes(3), '0, 8'h40, 8'h04, 0, 1); chk_cnt("R8 held true");
    ev('0, '0, 8'h40, 8'h04, 0, 1); chk_cnt("R8 false");
    ev(lanes(3), '0, 8'h40, 8'h04, 0, 1); exp_cnt += 1; chk_cnt("R8 second rise");
    wr(1'b0, mk(8'h40, 8'h04, 1, 1, 1, 0, 1, 0, 8'd0));
    ev(lanes(2), '0, 8'h40, 8'h04, 0, 1); exp_cnt += 2;
    ev(lanes(2), '0, 8'h40, 8'h04, 0, 1); exp_cnt += 2; chk_cnt("R8 ignored at zero threshold");
  endtask

  task automatic t_overflow();
    setup(mk(8'h3C, 8'h00, 1, 1, 0, 1, 1, 0, 8'd0), (~48'd5 + 48'd1) & M48);
    for (int k = 0; k < 4; k++) begin
      ev(lanes(1), '0, 8'h3C, 8'h00, 0, 1); exp_cnt += 1;
      chk("R9 no early pulse", {63'd0, ovf_pulse}, 64'd0);
    end
    chk_cnt("R9 all ones before wrap");
    ev(lanes(1), '0, 8'h3C, 8'h00, 0, 1); exp_cnt = 48'd0;
    chk_cnt("R9 wrapped to zero");
    chk("R9 pulse on wrap", {63'd0, ovf_pulse}, 64'd1);
    chk("R10 irq raised", {63'd0, irq}, 64'd1);
    @(negedge clk);
    chk("R9 pulse one cycle", {63'd0, ovf_pulse}, 64'd0);
    chk("R10 irq held", {63'd0, irq}, 64'd1);
    irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
    chk("R10 irq acknowledged", {63'd0, irq}, 64'd0);
    wr(1'b1, {16'd0, M48 - 48'd1}); exp_cnt = 48'd1;
    ev(lanes(3), '0, 8'h3C, 8'h00, 0, 1);
    chk_cnt("R9 multi-step wrap");
    chk("R9 multi-step pulse", {63'd0, ovf_pulse}, 64'd1);
    irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
    wr(1'b1, {16'd0, M48});
    irq_ack = 1'b1;
    ev(lanes(1), '0, 8'h3C, 8'h00, 0, 1);
    irq_ack = 1'b0;
    chk("R10 overflow beats ack", {63'd0, irq}, 64'd1);
    irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
    setup(mk(8'h3C, 8'h00, 1, 1, 0, 0, 1, 0, 8'd0), M48);
    ev(lanes(1), '0, 8'h3C, 8'h00, 0, 1);
    chk("R9 pulse without int", {63'd0, ovf_pulse}, 64'd1);
    chk("R10 no irq without int", {63'd0, irq}, 64'd0);
  endtask

  task automatic t_regs();
    logic [63:0] d;
    wr(1'b0, 64'hA5C3_0F1E_FF7F_2B3C);
    rd(1'b0, d); chk("R4 selector readback", d, 64'hA5C3_0F1E_FF7F_2B3C);
    wr(1'b1, 64'hFFFF_1234_5678_9ABC);
    rd(1'b1, d); chk("R4 count masked", d, 64'h0000_1234_5678_9ABC);
  endtask

  task automatic t_prio();
    setup(mk(8'h3C, 8'h00, 1, 1, 0, 0, 1, 0, 8'd0), 48'd50);
    reg_wr = 1'b1; reg_sel = 1'b1; reg_wdata = 64'h100;
    ev(lanes(3), '0, 8'h3C, 8'h00, 0, 1);
    reg_wr = 1'b0;
    exp_cnt = 48'h100; chk_cnt("R11 write wins");
    ev(lanes(1), '0, 8'h3C, 8'h00, 0, 1); exp_cnt += 1; chk_cnt("R11 counting resumes");
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; glb_en = 1'b0; priv_kernel = 1'b0; reg_wr = 1'b0; reg_sel = 1'b1;
    irq_ack = 1'b0; reg_wdata = '0; lane_valid = '0; lane_code = '0; lane_umask = '0;
    exp_cnt = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_match();
    t_priv();
    t_enable();
    t_sat();
    t_thresh();
    t_invert();
    t_edge();
    t_overflow();
    t_regs();
    t_prio();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule